// File: doc/BRIEF.md
# Carry-Save Tree Unsigned Multiplier

This block multiplies two unsigned operands of `N` bits each. The result is an exact product of `2N` bits, and the datapath has no registers. Each bit of the multiplier selects one summand. That summand is either the multiplicand moved left by the bit's index or an all-zero vector. The summands then pass through successive layers of 3:2 carry-save rows. A row takes three vectors and returns a sum vector and a carry vector, and no carry travels along the row. A layer groups its inputs in threes. Any vector that does not fill a group of three goes to the next layer unchanged. The layers repeat until only two vectors remain. A single ripple-carry adder then adds those two vectors to give the product.

The block is used as a purely combinational arithmetic stage. Every internal vector is `2N` bits wide. A carry vector always carries a weight one position above the sum vector it comes from. With six-bit operands, the six summands pass through four carry-save rows spread over three layers before the final addition.

Top module: `csa_tree_mult`

## Requirements
- R1: Summand k equals the multiplicand shifted left by k bit positions, zero-extended to 2N bits, when multiplier bit k is 1. It is all zeros when that bit is 0. A multiplier with only bit k set therefore gives a product equal to the multiplicand shifted left by k.
- R2: For every pair of unsigned N-bit operands, the 2N-bit product output equals the exact arithmetic product, with no truncation.
- R3: When either operand is zero, the product is zero.
- R4: The two vectors left after the last carry-save layer add, modulo 2^(2N), to the product output. This holds for dense multipliers where every layer is fully used.
- R5: With N = 6, the multiplicand 45 and the multiplier 63 give 2835.
- R6: Operands that are all ones give (2^N − 1)², which drives a carry through almost the whole final adder.
- R7: A multiplier of value 1 returns the multiplicand unchanged in the low N bits, and the high N bits are zero.
- R8: Exchanging the two operands does not change the product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mcand_i | input | N | Unsigned multiplicand |
| mplier_i | input | N | Unsigned multiplier; bit k enables summand k |
| product_o | output | 2N | Unsigned product |

## Verification
Two things resolve together in the same evaluation: the carry-save reduction of many active summands, and the long carry ripple in the final adder. Either one alone can hide a wrong weight or a dropped carry in the other. The stress is applied with all-ones operands, alternating bit patterns and dense random multipliers, so that every carry-save row produces carries and the last adder must ripple a carry over most of its width. The product is compared with a shift-and-add model written in the bench. The remaining sum/carry pair is checked separately: it must add to the same value.

// File: rtl/csm_pkg.sv
// Package csm_pkg
// Purpose : constant functions that size the carry-save reduction tree.
// Assumes : vector counts of 2 or more; a count of 2 or fewer needs no layer.
package csm_pkg;

    // Vector count after one layer: each group of three becomes two, leftovers pass.
    function automatic int unsigned csa_next_count(input int unsigned k);
        return 2 * (k / 3) + (k % 3);
    endfunction

    // Vector count present at layer lvl when k0 vectors enter layer 0.
    function automatic int unsigned csa_count_at(input int unsigned k0, input int unsigned lvl);
        int unsigned k;
        k = k0;
        for (int unsigned i = 0; i < lvl; i++) begin
            if (k > 2) k = csa_next_count(k);
        end
        return k;
    endfunction

    // Number of layers needed to bring k0 vectors down to two.
    function automatic int unsigned csa_layers(input int unsigned k0);
        int unsigned k;
        int unsigned n;
        k = k0;
        n = 0;
        for (int unsigned i = 0; i < 64; i++) begin
            if (k > 2) begin
                k = csa_next_count(k);
                n = n + 1;
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/csm_pp_gen.sv
// Module  csm_pp_gen
// Purpose : forms one summand per multiplier bit, i.e. the multiplicand
//           shifted left by the bit index, gated by that bit.
// Assumes : unsigned operands; summands are 2N bits wide and zero-extended.
module csm_pp_gen #(
    parameter int unsigned N = 8,
    localparam int unsigned W = 2 * N
) (
    input  logic [N-1:0] mcand_i,
    input  logic [N-1:0] mplier_i,
    output logic [W-1:0] pp_o [N]
);

    logic [W-1:0] mcand_ext;

    // Zero-extend the multiplicand to the full product width.
    assign mcand_ext = {{N{1'b0}}, mcand_i};

    generate
        for (genvar k = 0; k < N; k++) begin : g_row
            // Select the shifted multiplicand or zero for summand k.
            assign pp_o[k] = mplier_i[k] ? (mcand_ext << k) : '0;
        end
    endgenerate

endmodule

// File: rtl/csm_csa_row.sv
// Module  csm_csa_row
// Purpose : one 3:2 carry-save row over W bits; no carry moves along the row.
// Assumes : carry output is pre-shifted one position up; the carry out of the
//           top bit is discarded, which is safe because the final result is
//           taken modulo 2^W and the true product fits in W bits.
module csm_csa_row #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] z_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] carry_o
);

    logic [W-2:0] maj;

    // Bitwise sum of the three inputs at their own weight.
    assign sum_o = x_i ^ y_i ^ z_i;

    // Majority of the lower W-1 bit columns, which becomes the next column's carry.
    assign maj = (x_i[W-2:0] & y_i[W-2:0]) |
                 (x_i[W-2:0] & z_i[W-2:0]) |
                 (y_i[W-2:0] & z_i[W-2:0]);

    // Carry vector weighted one position above the sum vector.
    assign carry_o = {maj, 1'b0};

endmodule

// File: rtl/csm_reduce_tree.sv
// Module  csm_reduce_tree
// Purpose : reduces K vectors to a sum/carry pair through layers of 3:2 rows.
// Assumes : K >= 2; vectors left over after grouping by three pass through
//           the layer untouched; all vectors share width W.
module csm_reduce_tree
    import csm_pkg::*;
#(
    parameter int unsigned W = 16,
    parameter int unsigned K = 8
) (
    input  logic [W-1:0] vec_i [K],
    output logic [W-1:0] sum_o,
    output logic [W-1:0] carry_o
);

    localparam int unsigned LAYERS = csa_layers(K);

    generate
        for (genvar l = 0; l <= LAYERS; l++) begin : g_lyr
            localparam int unsigned CNT = csa_count_at(K, l);
            logic [W-1:0] v [CNT];

            if (l == 0) begin : g_in
                for (genvar j = 0; j < CNT; j++) begin : g_cp
                    // Layer 0 holds the incoming summands.
                    assign v[j] = vec_i[j];
                end
            end else begin : g_red
                localparam int unsigned PREV = csa_count_at(K, l - 1);
                localparam int unsigned GRP  = PREV / 3;
                localparam int unsigned REM  = PREV % 3;

                for (genvar g = 0; g < GRP; g++) begin : g_csa
                    csm_csa_row #(.W(W)) u_row (
                        .x_i    (g_lyr[l-1].v[3*g]),
                        .y_i    (g_lyr[l-1].v[3*g+1]),
                        .z_i    (g_lyr[l-1].v[3*g+2]),
                        .sum_o  (v[2*g]),
                        .carry_o(v[2*g+1])
                    );
                end

                for (genvar r = 0; r < REM; r++) begin : g_pass
                    // Leftover vectors move to the next layer unchanged.
                    assign v[2*GRP+r] = g_lyr[l-1].v[3*GRP+r];
                end
            end
        end
    endgenerate

    // The last layer holds exactly two vectors.
    assign sum_o   = g_lyr[LAYERS].v[0];
    assign carry_o = g_lyr[LAYERS].v[1];

endmodule

// File: rtl/csm_ripple_add.sv
// Module  csm_ripple_add
// Purpose : final carry-propagate adder built as a chain of full adders.
// Assumes : result is taken modulo 2^W; the carry out of the top bit is dropped.
module csm_ripple_add #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o
);

    logic [W-1:0] cy;

    // No carry enters the least significant position.
    assign cy[0] = 1'b0;

    generate
        for (genvar i = 0; i < W; i++) begin : g_fa
            // Sum bit of full adder i.
            assign sum_o[i] = a_i[i] ^ b_i[i] ^ cy[i];
            if (i < W - 1) begin : g_cy
                // Carry handed to full adder i+1.
                assign cy[i+1] = (a_i[i] & b_i[i]) | (cy[i] & (a_i[i] ^ b_i[i]));
            end
        end
    endgenerate

endmodule

// File: rtl/csa_tree_mult.sv
// Module  csa_tree_mult
// Purpose : combinational unsigned N x N multiplier. Gated shifted summands
//           are reduced by a carry-save tree and then added by a ripple adder.
// Assumes : unsigned operands, N >= 1; a single-bit multiplier gets a zero
//           vector as padding so that the tree always sees at least two inputs.
module csa_tree_mult #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0]   mcand_i,
    input  logic [N-1:0]   mplier_i,
    output logic [2*N-1:0] product_o
);

    localparam int unsigned W = 2 * N;
    localparam int unsigned K = (N < 2) ? 2 : N;

    logic [W-1:0] pp       [N];
    logic [W-1:0] summands [K];
    logic [W-1:0] red_s;
    logic [W-1:0] red_c;

    csm_pp_gen #(.N(N)) u_pp (
        .mcand_i (mcand_i),
        .mplier_i(mplier_i),
        .pp_o    (pp)
    );

    generate
        for (genvar j = 0; j < K; j++) begin : g_sum
            if (j < N) begin : g_real
                // Feed a real summand into the tree.
                assign summands[j] = pp[j];
            end else begin : g_pad
                // Pad the tree input when fewer than two summands exist.
                assign summands[j] = '0;
            end
        end
    endgenerate

    csm_reduce_tree #(.W(W), .K(K)) u_tree (
        .vec_i  (summands),
        .sum_o  (red_s),
        .carry_o(red_c)
    );

    csm_ripple_add #(.W(W)) u_cpa (
        .a_i  (red_s),
        .b_i  (red_c),
        .sum_o(product_o)
    );

endmodule

// File: rtl/csa_tree_mult_chk.sv
// Module  csa_tree_mult_chk
// Purpose : property checker for csa_tree_mult, attached by bind below.
// Assumes : the checked block is combinational, so immediate assertions run
//           whenever the inputs settle; unknown inputs are skipped.
module csa_tree_mult_chk #(
    parameter int unsigned N = 8,
    localparam int unsigned W = 2 * N
) (
    input logic [N-1:0] mcand_i,
    input logic [N-1:0] mplier_i,
    input logic [W-1:0] product_o,
    input logic [W-1:0] pp [N],
    input logic [W-1:0] red_s,
    input logic [W-1:0] red_c
);

    logic [W-1:0] a_ext;
    logic [W-1:0] b_ext;
    logic [W-1:0] pair_sum;

    // Widened operands and the plain sum of the final sum/carry pair.
    assign a_ext    = {{N{1'b0}}, mcand_i};
    assign b_ext    = {{N{1'b0}}, mplier_i};
    assign pair_sum = red_s + red_c;

    // Check summand gating, the exact product and its corner identities.
    always_comb begin
        if (!$isunknown({mcand_i, mplier_i})) begin
            for (int k = 0; k < N; k++) begin
                AST_PP_SELECT: assert (pp[k] == (mplier_i[k] ? (a_ext << k) : '0)) else $error("summand gating"); // R1
            end
            AST_PRODUCT_EXACT: assert (product_o == W'(a_ext * b_ext)) else $error("product mismatch"); // R2
            AST_ZERO_OPERAND: assert (!((mcand_i == '0) || (mplier_i == '0)) || (product_o == '0)) else $error("zero operand"); // R3
            AST_PAIR_SUM: assert (pair_sum == product_o) else $error("sum/carry pair"); // R4
            AST_UNIT_MULT: assert ((mplier_i != N'(1)) || (product_o == a_ext)) else $error("unit multiplier"); // R7
        end
    end

endmodule

bind csa_tree_mult csa_tree_mult_chk #(.N(N)) u_chk (
    .mcand_i  (mcand_i),
    .mplier_i (mplier_i),
    .product_o(product_o),
    .pp       (pp),
    .red_s    (red_s),
    .red_c    (red_c)
);

// File: tb/csa_tree_mult_tb_top.sv
// Bench for csa_tree_mult: directed corner cases plus seeded random operands,
// compared with a shift-and-add model written here.
module csa_tree_mult_tb_top;

    localparam int unsigned N  = 8;
    localparam int unsigned N6 = 6;

    logic clk;
    logic rst_n;
    logic [N-1:0]    a8, b8;
    logic [2*N-1:0]  p8;
    logic [N6-1:0]   a6, b6;
    logic [2*N6-1:0] p6;

    int  tests_run;
    int  tests_failed;
    bit  done;

    csa_tree_mult #(.N(N))  dut_i   (.mcand_i(a8), .mplier_i(b8), .product_o(p8));
    csa_tree_mult #(.N(N6)) dut6_i  (.mcand_i(a6), .mplier_i(b6), .product_o(p6));

    // 50 MHz clock.
    initial clk = 1'b0;
    always #10 clk = ~clk;

    // Shift-and-add reference product.
    function automatic longint unsigned model_mul(input longint unsigned a, input longint unsigned b, input int n);
        longint unsigned acc;
        acc = 0;
        for (int k = 0; k < n; k++) begin
            if (b[k]) acc = acc + (a << k);
        end
        return acc;
    endfunction

    task automatic check(input string req, input longint unsigned got, input longint unsigned exp);
        tests_run++;
        if (got !== exp) begin
            tests_failed++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Apply operands to the 8-bit instance away from the clock edge, then check.
    task automatic run8(input string req, input logic [N-1:0] a, input logic [N-1:0] b);
        @(posedge clk);
        #5;
        a8 = a;
        b8 = b;
        #5;
        check(req, longint'(p8), model_mul(longint'(a), longint'(b), N));
    endtask

    task automatic run6(input string req, input logic [N6-1:0] a, input logic [N6-1:0] b, input longint unsigned exp);
        @(posedge clk);
        #5;
        a6 = a;
        b6 = b;
        #5;
        check(req, longint'(p6), exp);
    endtask

    // Watchdog: a hung run counts as one failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests_run++;
            tests_failed++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] ra, rb;
        logic [15:0]  swp;
        tests_run    = 0;
        tests_failed = 0;
        done         = 1'b0;
        a8 = '0; b8 = '0; a6 = '0; b6 = '0;
        rst_n = 1'b0;
        void'($urandom(32'h5EED_C5A1));
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        // Start state: zero operands give zero (R3).
        #5;
        check("R3 idle zero", longint'(p8), 0);

        // R5: worked six-bit example, and R6 for six bits.
        run6("R5 45x63", 6'd45, 6'd63, 2835);
        run6("R6 63x63 six-bit", 6'h3F, 6'h3F, 3969);

        // R6: all ones for eight bits.
        run8("R6 all ones", 8'hFF, 8'hFF);
        check("R6 all ones value", longint'(p8), 65025);

        // R3: either operand zero.
        run8("R3 mcand zero", 8'h00, 8'hB7);
        check("R3 mcand zero is zero", longint'(p8), 0);
        run8("R3 mplier zero", 8'hFF, 8'h00);
        check("R3 mplier zero is zero", longint'(p8), 0);

        // R1: a single multiplier bit selects one shifted summand.
        for (int k = 0; k < N; k++) begin
            run8("R1 single bit", 8'hD3, 8'(1 << k));
            check("R1 shifted mcand", longint'(p8), longint'(16'hD3) << k);
        end

        // R7: unit multiplier.
        run8("R7 unit", 8'hA9, 8'h01);
        check("R7 unit value", longint'(p8), 169);

        // R4: alternating and dense patterns load every carry-save row.
        run8("R4 alt AA x 55", 8'hAA, 8'h55);
        run8("R4 alt 55 x AA", 8'h55, 8'hAA);
        run8("R4 dense FF x FE", 8'hFF, 8'hFE);
        run8("R4 dense 7F x FF", 8'h7F, 8'hFF);

        // R2 / R4 / R8: seeded random operands, half with dense multipliers.
        for (int t = 0; t < 2000; t++) begin
            ra = 8'($urandom);
            rb = 8'($urandom);
            if (t % 2 == 1) rb = rb | 8'($urandom);
            run8((t % 2 == 1) ? "R4 random dense" : "R2 random", ra, rb);
            swp = p8;
            run8("R8 swapped", rb, ra);
            check("R8 swap equal", longint'(p8), longint'(swp));
        end

        // R2: random six-bit operands on the second instance.
        for (int t = 0; t < 200; t++) begin
            ra = 8'($urandom);
            rb = 8'($urandom);
            run6("R2 random six-bit", ra[5:0], rb[5:0], model_mul(longint'(ra[5:0]), longint'(rb[5:0]), N6));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule